// File: doc/BRIEF.md
# Matrix Keyboard Scan Controller

The controller walks a key matrix of up to 16 rows and 8 columns. It drives one row line high at a time, holds it for a fixed dwell, and samples the column inputs at the end of that dwell. After the last row it turns the keys found down into one snapshot. A snapshot holds up to eight key entries, kept in row-major order, and is pushed into a small FIFO. Software reads each snapshot as two 32-bit words.

A simple register port serves all control and status. The control word holds the enable, the two interrupt enables, a 10-bit debounce extension of the row dwell and a 4-bit FIFO threshold. The status word holds two sticky interrupt flags, which are cleared by writing ones to them, and the live FIFO occupancy. Other registers hold the repeat delay and one column mask per row. A masked key still appears in snapshots but cannot raise the keypress flag. `irq_o` is the OR of each flag gated by its enable.

Register offsets (byte addresses): 0x00 control, 0x04 status, 0x08 entry word 0, 0x0C entry word 1, 0x10 repeat delay, 0x40 + 4*r mask of row r.

Top module: `kbd_matrix_ctrl`

## Requirements
- R1: After reset the status word, both entry words, `row_o` and `irq_o` all read 0.
- R2: With control bit 0 set, each scan waits 5 cycles with no row driven. It then drives rows 0 up to the last row one-hot, each for 16 plus the debounce count cycles. The debounce count sits in control bits 13:4.
- R3: An entry byte is bit 7 valid, bits 6:3 row and bits 2:0 column. Entry k sits in word k/4 at byte k%4, so entry 0 is in bits 7:0 of word 0 at offset 0x08.
- R4: Entries are ordered by row, then by column, in ascending order. Keys beyond the eighth are dropped, and unused entry bytes read 0.
- R5: Reading entry word 1 (offset 0x0C) pops one snapshot. Status bits 7:4 give the number of snapshots held. The entry words read 0 when the FIFO is empty.
- R6: A scan that finds no key down pushes nothing.
- R7: When the FIFO is full (default depth 4), new snapshots are dropped and the count stays at the depth.
- R8: A snapshot is pushed when its key set differs from the previous scan's set. Otherwise it is pushed only once at least the repeat delay (offset 0x10, in cycles) has passed since the last push.
- R9: Status bit 2 is set once the FIFO count is at or above the nonzero threshold in control bits 17:14. `irq_o` follows it when control bit 3 is set.
- R10: Writing 1 to a status bit clears it, unless its set condition still holds.
- R11: Status bit 0 is set when a scan sees a key whose bit in its row mask is 0. `irq_o` follows it when control bit 1 is set. Masked keys still appear in snapshots.
- R12: With control bit 0 clear, no row is driven and no snapshot is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| row_o | output | 16 | Row drive, one-hot while scanning |
| col_i | input | 8 | Column sense, 1 = key closed on driven row |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures the row dwell with and without a debounce count, and the idle gap between scans. A design off by one cycle in either counter fails there. It packs patterns that span rows and a pattern of nine keys. Wrong byte order, wrong column priority or a missing truncation shows up as wrong entry words. It holds keys longer than the FIFO can absorb and against a repeat delay that falls between one and two scan periods. A counter that overflows, or repeat logic that pushes too early or too late, gives a wrong count. Masked keys, threshold crossings and write-one-to-clear are checked through status bits and `irq_o`, where a flag that sticks or ignores its mask is visible directly.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int ENT_N  = 8;
  localparam int ENT_W  = 8;
  localparam int SNAP_W = ENT_N * ENT_W;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_ENT0 = 8'h08;
  localparam logic [7:0] A_ENT1 = 8'h0C;
  localparam logic [7:0] A_RPT  = 8'h10;
  localparam logic [1:0] A_MASK_HI = 2'b01;  // 0x40..0x7C

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_INIT,
    SEQ_ROW
  } seq_state_e;
endpackage

// File: rtl/kbd_scan_seq.sv
module kbd_scan_seq #(
  parameter int ROWS         = 16,
  parameter int INIT_CYC     = 5,
  parameter int ROW_BASE_CYC = 16,
  parameter int DEB_W        = 10,
  localparam int RW          = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DEB_W-1:0] deb_i,
  output logic [ROWS-1:0]  row_o,
  output logic [RW-1:0]    row_idx_o,
  output logic             sample_o,
  output logic             done_o
);
  import kbd_pkg::*;

  localparam int TW = DEB_W + 2;
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  seq_state_e    st_q;
  logic [TW-1:0] cnt_q;
  logic [RW-1:0] row_q;
  logic [TW-1:0] dwell_m1;

  assign dwell_m1 = TW'(ROW_BASE_CYC - 1) + TW'(deb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      row_q <= '0;
    end else if (!en_i) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      row_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          st_q  <= SEQ_INIT;
          cnt_q <= TW'(INIT_CYC - 1);
        end
        SEQ_INIT: begin
          if (cnt_q == '0) begin
            st_q  <= SEQ_ROW;
            row_q <= '0;
            cnt_q <= dwell_m1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_ROW: begin
          if (cnt_q == '0) begin
            if (row_q == LAST_ROW) begin
              st_q  <= SEQ_INIT;
              cnt_q <= TW'(INIT_CYC - 1);
            end else begin
              row_q <= row_q + 1'b1;
              cnt_q <= dwell_m1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_o[r] = (st_q == SEQ_ROW) && (row_q == RW'(r));
  end

  assign row_idx_o = row_q;
  assign sample_o  = (st_q == SEQ_ROW) && (cnt_q == '0);
  assign done_o    = sample_o && (row_q == LAST_ROW);

  AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_o));  // R2
  AST_OFF_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (row_o == '0));  // R12
  AST_ROW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((row_o != '0) && !sample_o && en_i) |=> $stable(row_o));  // R2
endmodule

// File: rtl/kbd_snap_pack.sv
module kbd_snap_pack #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sample_i,
  input  logic                      done_i,
  input  logic [RW-1:0]             row_i,
  input  logic [COLS-1:0]           col_i,
  output logic                      snap_vld_o,
  output logic [kbd_pkg::SNAP_W-1:0] snap_o
);
  import kbd_pkg::*;

  logic [SNAP_W-1:0] acc_q, base, ents;
  logic [3:0]        acc_n_q, base_n, n;
  logic [ENT_N-1:0]  vmask;

  always_comb begin
    base   = (row_i == '0) ? '0 : acc_q;
    base_n = (row_i == '0) ? '0 : acc_n_q;
    ents   = base;
    n      = base_n;
    for (int c = 0; c < COLS; c++) begin
      if (col_i[c] && (n < 4'(ENT_N))) begin
        ents[n*ENT_W +: ENT_W] = {1'b1, 4'(row_i), 3'(c)};
        n = n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      acc_n_q    <= '0;
      snap_o     <= '0;
      snap_vld_o <= 1'b0;
    end else begin
      snap_vld_o <= 1'b0;
      if (sample_i) begin
        if (done_i) begin
          snap_o     <= ents;
          snap_vld_o <= 1'b1;
          acc_q      <= '0;
          acc_n_q    <= '0;
        end else begin
          acc_q   <= ents;
          acc_n_q <= n;
        end
      end
    end
  end

  for (genvar k = 0; k < ENT_N; k++) begin : g_v
    assign vmask[k] = snap_o[k*ENT_W + ENT_W - 1];
  end

  AST_ENT_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_vld_o |-> ((vmask & (vmask + 1'b1)) == '0));  // R4
endmodule

// File: rtl/kbd_snap_fifo.sv
module kbd_snap_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= data_i;
        wp_q        <= inc(wp_q);
      end
      if (do_pop) rp_q <= inc(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign head_o = (cnt_q == '0) ? '0 : mem_q[rp_q];
  assign cnt_o  = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));  // R7
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_o == CW'(DEPTH)) && !pop_i) |=> (cnt_o == CW'(DEPTH)));  // R7
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_o == '0) && !push_i) |=> (cnt_o == '0));  // R5
endmodule

// File: rtl/kbd_matrix_ctrl.sv
module kbd_matrix_ctrl #(
  parameter int ROWS         = 16,
  parameter int COLS         = 8,
  parameter int FIFO_DEPTH   = 4,
  parameter int INIT_CYC     = 5,
  parameter int ROW_BASE_CYC = 16,
  parameter int DEB_W        = 10,
  parameter int THR_W        = 4,
  parameter int RPT_W        = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_req_i,
  input  logic            reg_we_i,
  input  logic [7:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  output logic [ROWS-1:0] row_o,
  input  logic [COLS-1:0] col_i,
  output logic            irq_o
);
  import kbd_pkg::*;

  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int DEB_LSB = 4;
  localparam int THR_LSB = 14;

  logic             en_q, kp_ie_q, fifo_ie_q;
  logic [DEB_W-1:0] deb_q;
  logic [THR_W-1:0] thr_q;
  logic [RPT_W-1:0] rpt_q, rpt_cnt_q;
  logic [ROWS-1:0][COLS-1:0] mask_q;
  logic             kp_st_q, fifo_st_q;
  logic [SNAP_W-1:0] last_q;

  logic wr, rd, mask_sel;
  logic [RW-1:0]  row_idx;
  logic           sample, done, snap_vld, push, pop;
  logic [SNAP_W-1:0] snap, head;
  logic [CW-1:0]  fcnt;
  logic           kp_set, fifo_set;

  assign wr       = reg_req_i && reg_we_i;
  assign rd       = reg_req_i && !reg_we_i;
  assign mask_sel = (reg_addr_i[7:6] == A_MASK_HI);
  assign pop      = rd && (reg_addr_i == A_ENT1);

  kbd_scan_seq #(
    .ROWS(ROWS), .INIT_CYC(INIT_CYC), .ROW_BASE_CYC(ROW_BASE_CYC), .DEB_W(DEB_W)
  ) u_seq (
    .clk_i, .rst_ni, .en_i(en_q), .deb_i(deb_q), .row_o,
    .row_idx_o(row_idx), .sample_o(sample), .done_o(done)
  );

  kbd_snap_pack #(.ROWS(ROWS), .COLS(COLS)) u_pack (
    .clk_i, .rst_ni, .sample_i(sample), .done_i(done), .row_i(row_idx),
    .col_i, .snap_vld_o(snap_vld), .snap_o(snap)
  );

  kbd_snap_fifo #(.W(SNAP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .data_i(snap), .pop_i(pop),
    .head_o(head), .cnt_o(fcnt)
  );

  // push on change, or on repeat expiry while the same set is held
  assign push = en_q && snap_vld && snap[ENT_W-1] &&
                ((snap != last_q) || (rpt_cnt_q >= rpt_q));

  assign kp_set   = en_q && sample && |(col_i & ~mask_q[row_idx]);
  assign fifo_set = (thr_q != '0) && (THR_W'(fcnt) >= thr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      kp_ie_q   <= 1'b0;
      fifo_ie_q <= 1'b0;
      deb_q     <= '0;
      thr_q     <= '0;
      rpt_q     <= '0;
      mask_q    <= '0;
    end else if (wr) begin
      if (reg_addr_i == A_CTRL) begin
        en_q      <= reg_wdata_i[0];
        kp_ie_q   <= reg_wdata_i[1];
        fifo_ie_q <= reg_wdata_i[3];
        deb_q     <= reg_wdata_i[DEB_LSB +: DEB_W];
        thr_q     <= reg_wdata_i[THR_LSB +: THR_W];
      end
      if (reg_addr_i == A_RPT) rpt_q <= reg_wdata_i[RPT_W-1:0];
      for (int r = 0; r < ROWS; r++) begin
        if (mask_sel && (reg_addr_i[5:2] == 4'(r))) mask_q[r] <= reg_wdata_i[COLS-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kp_st_q   <= 1'b0;
      fifo_st_q <= 1'b0;
    end else begin
      kp_st_q   <= (kp_st_q & ~(wr && reg_addr_i == A_STAT && reg_wdata_i[0])) | kp_set;
      fifo_st_q <= (fifo_st_q & ~(wr && reg_addr_i == A_STAT && reg_wdata_i[2])) | fifo_set;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpt_cnt_q <= '0;
      last_q    <= '0;
    end else if (!en_q) begin
      rpt_cnt_q <= '0;
      last_q    <= '0;
    end else begin
      if (push) rpt_cnt_q <= '0;
      else if (rpt_cnt_q != '1) rpt_cnt_q <= rpt_cnt_q + 1'b1;
      if (snap_vld) last_q <= snap;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (mask_sel) begin
      for (int r = 0; r < ROWS; r++)
        if (reg_addr_i[5:2] == 4'(r)) reg_rdata_o[COLS-1:0] = mask_q[r];
    end else begin
      unique case (reg_addr_i)
        A_CTRL: begin
          reg_rdata_o[0] = en_q;
          reg_rdata_o[1] = kp_ie_q;
          reg_rdata_o[3] = fifo_ie_q;
          reg_rdata_o[DEB_LSB +: DEB_W] = deb_q;
          reg_rdata_o[THR_LSB +: THR_W] = thr_q;
        end
        A_STAT: begin
          reg_rdata_o[0]   = kp_st_q;
          reg_rdata_o[2]   = fifo_st_q;
          reg_rdata_o[7:4] = 4'(fcnt);
        end
        A_ENT0: reg_rdata_o = head[31:0];
        A_ENT1: reg_rdata_o = head[63:32];
        A_RPT:  reg_rdata_o[RPT_W-1:0] = rpt_q;
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = (kp_st_q && kp_ie_q) || (fifo_st_q && fifo_ie_q);

  AST_NO_SPURIOUS_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop |=> (fcnt >= $past(fcnt)));  // R5
  AST_OFF_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !pop) |=> (fcnt == $past(fcnt)));  // R12
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kp_ie_q && !fifo_ie_q) |-> !irq_o);  // R9
endmodule

// File: tb/tb_kbd_matrix_ctrl.sv
`timescale 1ns/1ps
module tb_kbd_matrix_ctrl;
  localparam int PERIOD = 5 + 16 * 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] row;
  logic [7:0]  col;
  logic        irq;
  logic [15:0][7:0] keys = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    col = '0;
    for (int r = 0; r < 16; r++) if (row[r]) col = col | keys[r];
  end

  kbd_matrix_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .row_o(row), .col_i(col), .irq_o(irq)
  );

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic fcount(output int n);
    logic [31:0] s;
    rd(8'h04, s);
    n = int'(s[7:4]);
  endtask

  task automatic quiesce();
    logic [31:0] d;
    int n;
    wr(8'h00, 32'h0);
    keys = '0;
    fcount(n);
    for (int i = 0; i < 8 && n > 0; i++) begin
      rd(8'h0C, d);
      fcount(n);
    end
    wr(8'h04, 32'h5);
    wr(8'h10, 32'h0);
  endtask

  task automatic wait_scans(input int n);
    repeat (n * PERIOD + 20) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h08, d); chk("R1 entry0", d, 0);
    rd(8'h0C, d); chk("R1 entry1", d, 0);
    chk("R1 rows", 32'(row), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic dwell(input logic [15:0] pat, output int n);
    int g = 0;
    n = 0;
    while (row != pat && g < 40000) begin @(negedge clk); g++; end
    while (row == pat && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic t_timing();
    int n, gap;
    wr(8'h00, 32'h1);
    dwell(16'h0001, n);
    chk("R2 dwell deb0", n, 16);
    dwell(16'h8000, n);
    gap = 0;
    while (row == '0 && gap < 100) begin @(negedge clk); gap++; end
    chk("R2 init gap", gap, 5);
    chk("R2 restart row0", 32'(row), 1);
    wr(8'h00, 32'h0);
    wr(8'h00, (32'd3 << 4) | 32'h1);
    dwell(16'h0001, n);
    chk("R2 dwell deb3", n, 19);
    quiesce();
  endtask

  task automatic t_single();
    logic [31:0] d;
    int n;
    keys[2][5] = 1'b1;
    wr(8'h00, 32'h1);
    wait_scans(1);
    fcount(n); chk("R5 count one", n, 1);
    rd(8'h08, d); chk("R3 single word0", d, 32'h0000_0095);
    rd(8'h0C, d); chk("R3 single word1", d, 0);
    quiesce();
  endtask

  task automatic t_multi();
    logic [31:0] d;
    keys[0][1] = 1'b1; keys[0][6] = 1'b1; keys[3][0] = 1'b1; keys[9][7] = 1'b1;
    wr(8'h00, 32'h1);
    wait_scans(1);
    rd(8'h08, d); chk("R4 order word0", d, 32'hCF98_8681);
    rd(8'h0C, d); chk("R4 order word1", d, 0);
    quiesce();
  endtask

  task automatic t_trunc();
    logic [31:0] d;
    int n;
    keys[4] = 8'hFF; keys[5][0] = 1'b1;
    wr(8'h00, 32'h1);
    wait_scans(1);
    wr(8'h00, 32'h0);
    rd(8'h08, d); chk("R4 trunc word0", d, 32'hA3A2_A1A0);
    rd(8'h0C, d); chk("R4 trunc word1", d, 32'hA7A6_A5A4);
    fcount(n); chk("R5 popped", n, 0);
    rd(8'h08, d); chk("R5 empty reads 0", d, 0);
    quiesce();
  endtask

  task automatic t_idle();
    int n;
    wr(8'h00, 32'h1);
    wait_scans(3);
    fcount(n); chk("R6 no keys no push", n, 0);
    quiesce();
  endtask

  task automatic t_overflow();
    int n;
    logic [31:0] d;
    keys[1][1] = 1'b1;
    wr(8'h00, 32'h1);
    wait_scans(6);
    wr(8'h00, 32'h0);
    fcount(n); chk("R7 saturate", n, 4);
    for (int i = 0; i < 4; i++) rd(8'h0C, d);
    fcount(n); chk("R7 drained", n, 0);
    quiesce();
  endtask

  task automatic t_repeat();
    int n;
    keys[7][2] = 1'b1;
    wr(8'h10, 32'd100000);
    wr(8'h00, 32'h1);
    wait_scans(3);
    wr(8'h00, 32'h0);
    fcount(n); chk("R8 long repeat one push", n, 1);
    quiesce();
    keys[7][2] = 1'b1;
    wr(8'h10, 32'd300);
    wr(8'h00, 32'h1);
    wait_scans(5);
    wr(8'h00, 32'h0);
    fcount(n); chk("R8 repeat every other scan", n, 3);
    quiesce();
  endtask

  task automatic t_irq_fifo();
    logic [31:0] d;
    keys[3][3] = 1'b1;
    wr(8'h00, (32'd2 << 14) | 32'h9);
    wait_scans(1);
    rd(8'h04, d); chk("R9 below threshold", d & 32'hF4, 32'h10);
    chk("R9 irq low", 32'(irq), 0);
    wait_scans(1);
    rd(8'h04, d); chk("R9 at threshold", d & 32'hF4, 32'h24);
    chk("R9 irq high", 32'(irq), 1);
    wr(8'h00, (32'd2 << 14) | 32'h8);
    rd(8'h0C, d); rd(8'h0C, d);
    chk("R10 flag sticky", 32'(irq), 1);
    wr(8'h04, 32'h4);
    rd(8'h04, d); chk("R10 w1c cleared", d & 32'h4, 0);
    chk("R10 irq low", 32'(irq), 0);
    quiesce();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h48, 32'h20);
    rd(8'h48, d); chk("R11 mask readback", d, 32'h20);
    keys[2][5] = 1'b1;
    wr(8'h00, 32'h3);
    wait_scans(1);
    wr(8'h00, 32'h2);
    rd(8'h04, d); chk("R11 masked no kp", d & 32'hF1, 32'h10);
    chk("R11 masked irq low", 32'(irq), 0);
    rd(8'h08, d); chk("R11 masked still packed", d, 32'h95);
    quiesce();
    wr(8'h48, 32'h0);
    keys[2][5] = 1'b1;
    wr(8'h00, 32'h3);
    wait_scans(1);
    wr(8'h00, 32'h2);
    rd(8'h04, d); chk("R11 unmasked kp", d & 32'h1, 1);
    chk("R11 irq high", 32'(irq), 1);
    wr(8'h04, 32'h1);
    chk("R10 kp w1c", 32'(irq), 0);
    quiesce();
  endtask

  task automatic t_disable();
    int n, seen = 0;
    keys[6][4] = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (row != '0) seen++;
    end
    chk("R12 no row driven", seen, 0);
    fcount(n); chk("R12 no push", n, 0);
    quiesce();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timing();
    t_single();
    t_multi();
    t_trunc();
    t_idle();
    t_overflow();
    t_repeat();
    t_irq_fifo();
    t_mask();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule